// File: doc/BRIEF.md
# Sandcastle Clamp and Blanking Generator

This block builds a two-level sandcastle code for a display timing path. Its upper level is a video clamp pulse of fixed length. The pulse is launched by one edge of the normalized horizontal sync, and a configuration bit picks which edge. Its lower level is a vertical blanking pulse. That pulse opens on the rising edge of normalized vertical sync and lasts for one of two configurable cycle counts.

On top of the vertical blanking, several fault and status flags can hold the blanking level on continuously. These are soft start, missing flyback, X-ray trip and low supply. Horizontal unlock during frequency search also counts, unless a disable bit masks it.

All durations are counted in cycles of the system clock. The output is a two-bit level code that a later stage turns into the analog sandcastle levels. Both sync inputs arrive already sliced and polarity-normalized, meaning active-high.

Top module: `sc_sandcastle_gen`

## Requirements
- R1: The level code is 2'b00 for scan, 2'b01 for blanking and 2'b10 for clamp. The code 2'b11 never appears.
- R2: With `cfg_clamp_lead`=1, a rising edge of `hsync` sampled at clock edge k makes the output clamp for exactly `CLAMP_CYC` cycles, starting right after edge k.
- R3: With `cfg_clamp_lead`=0, the clamp is launched in the same way by a falling edge of `hsync`. A rising edge then launches nothing.
- R4: A trigger edge that arrives while a clamp is running is ignored. The clamp still ends `CLAMP_CYC` cycles after its own start.
- R5: Clamp has priority over every blanking cause: while the clamp runs, the code is 2'b10.
- R6: A rising edge of `vsync` starts vertical blanking. It lasts `VB_SHORT_CYC` cycles when `cfg_vblank_long`=0 and `VB_LONG_CYC` cycles when it is 1. The choice is taken at the starting edge.
- R7: A rising edge of `vsync` during vertical blanking is ignored and does not extend it.
- R8: While any of `st_softstart`, `st_no_flyback`, `st_xray` or `st_low_supply` is 1, the code is blanking unless a clamp runs.
- R9: `st_hunlock` and `st_search` both at 1 force blanking, unless `cfg_unlock_blank_off`=1. The disable bit leaves vertical blanking unaffected.
- R10: From reset, the output shows blanking, or clamp when a clamp runs. This lasts until the first vertical blanking pulse has run out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync | input | 1 | Normalized horizontal sync, active-high |
| vsync | input | 1 | Normalized vertical sync, active-high |
| cfg_clamp_lead | input | 1 | 1: clamp on hsync leading edge, 0: on trailing edge |
| cfg_vblank_long | input | 1 | 1: long vertical blanking, 0: short |
| cfg_unlock_blank_off | input | 1 | 1: mask continuous blanking from horizontal unlock |
| st_softstart | input | 1 | Soft start in progress |
| st_hunlock | input | 1 | Horizontal loop unlocked |
| st_search | input | 1 | Frequency search running |
| st_no_flyback | input | 1 | Flyback pulses missing |
| st_xray | input | 1 | X-ray protection tripped |
| st_low_supply | input | 1 | Supply voltage low |
| level_o | output | 2 | Sandcastle level code |

## Verification
The assertions assume three things about the inputs. Sync and status inputs are synchronous to `clk`. Both sync inputs are already normalized. Every configured width is at least one cycle, with `VB_LONG_CYC` no smaller than `VB_SHORT_CYC`.

The stimulus follows the same assumptions. It changes every input only on the falling clock edge, and it draws sync periods from bounded ranges. It also deliberately places trigger edges inside running pulses, so that the retrigger rules are exercised. Fault flags are raised in short bursts that overlap both pulses.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    LVL_SCAN  = 2'b00,
    LVL_BLANK = 2'b01,
    LVL_CLAMP = 2'b10
  } sc_level_e;

  function automatic logic [1:0] sc_encode(input logic clamp, input logic blank);
    if (clamp)      return LVL_CLAMP;
    else if (blank) return LVL_BLANK;
    else            return LVL_SCAN;
  endfunction
endpackage

// File: rtl/sc_edge_det.sv
module sc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/sc_oneshot.sv
module sc_oneshot #(
  parameter int MAXW = 70,
  localparam int CW  = $clog2(MAXW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic [CW-1:0] width_i,
  output logic          active_o,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (cnt_q != '0)              cnt_q <= cnt_q - CW'(1);
    else if (trig_i)                   cnt_q <= width_i;
  end

  assign active_o = (cnt_q != '0);
  assign last_o   = (cnt_q == CW'(1));

  AST_ONESHOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && !active_o) |=> (cnt_q == $past(width_i))) else $error("oneshot load"); // R2
  AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && active_o) |=> (cnt_q == $past(cnt_q) - CW'(1))) else $error("retrigger"); // R4
endmodule

// File: rtl/sc_force_blank.sv
module sc_force_blank (
  input  logic clk,
  input  logic rst_n,
  input  logic st_softstart,
  input  logic st_hunlock,
  input  logic st_search,
  input  logic st_no_flyback,
  input  logic st_xray,
  input  logic st_low_supply,
  input  logic unlock_off_i,
  output logic force_o
);
  logic fault;
  logic unlock;

  assign fault   = st_softstart | st_no_flyback | st_xray | st_low_supply;
  assign unlock  = st_hunlock & st_search & ~unlock_off_i;
  assign force_o = fault | unlock;

  AST_UNLOCK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_off_i && !fault) |-> !force_o) else $error("unlock mask"); // R9
endmodule

// File: rtl/sc_sandcastle_gen.sv
module sc_sandcastle_gen #(
  parameter int CLAMP_CYC    = 70,
  parameter int VB_SHORT_CYC = 26000,
  parameter int VB_LONG_CYC  = 35000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync,
  input  logic       vsync,
  input  logic       cfg_clamp_lead,
  input  logic       cfg_vblank_long,
  input  logic       cfg_unlock_blank_off,
  input  logic       st_softstart,
  input  logic       st_hunlock,
  input  logic       st_search,
  input  logic       st_no_flyback,
  input  logic       st_xray,
  input  logic       st_low_supply,
  output logic [1:0] level_o
);
  import sc_pkg::*;

  localparam int VB_MAX = (VB_LONG_CYC > VB_SHORT_CYC) ? VB_LONG_CYC : VB_SHORT_CYC;
  localparam int CCW    = $clog2(CLAMP_CYC + 1);
  localparam int VCW    = $clog2(VB_MAX + 1);
  localparam int RW     = CCW + 1;

  logic h_rise, h_fall, v_rise, v_fall;
  logic clamp_trig, clamp_act, clamp_last;
  logic vb_act, vb_last, force_blank;
  logic init_q;
  logic [VCW-1:0] vb_width;

  sc_edge_det u_hedge (.clk(clk), .rst_n(rst_n), .sig_i(hsync), .rise_o(h_rise), .fall_o(h_fall));
  sc_edge_det u_vedge (.clk(clk), .rst_n(rst_n), .sig_i(vsync), .rise_o(v_rise), .fall_o(v_fall));

  assign clamp_trig = cfg_clamp_lead ? h_rise : h_fall;

  sc_oneshot #(.MAXW(CLAMP_CYC)) u_clamp (
    .clk(clk), .rst_n(rst_n), .trig_i(clamp_trig),
    .width_i(CCW'(CLAMP_CYC)), .active_o(clamp_act), .last_o(clamp_last)
  );

  assign vb_width = cfg_vblank_long ? VCW'(VB_LONG_CYC) : VCW'(VB_SHORT_CYC);

  sc_oneshot #(.MAXW(VB_MAX)) u_vblank (
    .clk(clk), .rst_n(rst_n), .trig_i(v_rise),
    .width_i(vb_width), .active_o(vb_act), .last_o(vb_last)
  );

  sc_force_blank u_force (
    .clk(clk), .rst_n(rst_n),
    .st_softstart(st_softstart), .st_hunlock(st_hunlock), .st_search(st_search),
    .st_no_flyback(st_no_flyback), .st_xray(st_xray), .st_low_supply(st_low_supply),
    .unlock_off_i(cfg_unlock_blank_off), .force_o(force_blank)
  );

  // Hold blanking from reset until the first vertical scan begins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       init_q <= 1'b1;
    else if (vb_last) init_q <= 1'b0;
  end

  assign level_o = sc_encode(clamp_act, vb_act | force_blank | init_q);

  // Checker state: length of the current clamp run.
  logic [RW-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (clamp_act) run_q <= run_q + RW'(1);
    else                run_q <= '0;
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    level_o != 2'b11) else $error("illegal code"); // R1
  AST_CLAMP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_act) |-> (run_q == RW'(CLAMP_CYC))) else $error("clamp width"); // R2
  AST_CLAMP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_act && (vb_act || force_blank)) |-> (level_o == LVL_CLAMP)) else $error("prio"); // R5
  AST_FAULT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_xray || st_softstart || st_no_flyback || st_low_supply) && !clamp_act)
      |-> (level_o == LVL_BLANK)) else $error("fault blank"); // R8
  AST_INIT_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> (level_o != LVL_SCAN)) else $error("init blank"); // R10
  AST_VB_START: assert property (@(posedge clk) disable iff (!rst_n)
    (v_rise && !vb_act) |=> vb_act) else $error("vblank start"); // R6

  logic unused_ok;
  assign unused_ok = v_fall ^ clamp_last;
endmodule

// File: tb/sc_sandcastle_gen_tb.sv
module sc_sandcastle_gen_tb;
  localparam int CW = 8;
  localparam int VS = 40;
  localparam int VL = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync = 0, vsync = 0;
  logic lead = 1, vlong = 0, uoff = 0;
  logic ss = 0, hu = 0, srch = 0, nfb = 0, xr = 0, lows = 0;
  logic [1:0] level;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  sc_sandcastle_gen #(.CLAMP_CYC(CW), .VB_SHORT_CYC(VS), .VB_LONG_CYC(VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .cfg_clamp_lead(lead), .cfg_vblank_long(vlong), .cfg_unlock_blank_off(uoff),
    .st_softstart(ss), .st_hunlock(hu), .st_search(srch), .st_no_flyback(nfb),
    .st_xray(xr), .st_low_supply(lows), .level_o(level)
  );

  // Reference model built from the requirements.
  bit m_hp, m_vp, m_init;
  int m_c, m_v;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hp <= 0; m_vp <= 0; m_c <= 0; m_v <= 0; m_init <= 1;
    end else begin
      bit tr;
      tr = lead ? (hsync && !m_hp) : (!hsync && m_hp);
      if (m_c != 0) m_c <= m_c - 1;
      else if (tr) m_c <= CW;
      if (m_v != 0) m_v <= m_v - 1;
      else if (vsync && !m_vp) m_v <= vlong ? VL : VS;
      if (m_v == 1) m_init <= 0;
      m_hp <= hsync; m_vp <= vsync;
    end
  end

  function automatic bit fault_on();
    return ss | nfb | xr | lows;
  endfunction
  function automatic bit unlock_on();
    return hu & srch & ~uoff;
  endfunction
  function automatic logic [1:0] exp_level();
    if (m_c != 0) return 2'b10;
    if (m_v != 0 || fault_on() || unlock_on() || m_init) return 2'b01;
    return 2'b00;
  endfunction
  function automatic string exp_tag();
    if (m_c != 0) return (m_v != 0 || fault_on() || unlock_on() || m_init) ? "R5" : (lead ? "R2" : "R3");
    if (m_init) return "R10";
    if (fault_on()) return "R8";
    if (unlock_on()) return "R9";
    if (m_v != 0) return "R6";
    return "R1";
  endfunction

  task automatic chk(input logic [1:0] got, input logic [1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: level got=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on && rst_n && !done) chk(level, exp_level(), exp_tag());

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(2);
    chk(level, 2'b01, "R10 reset");
    rst_n = 1;
    model_on = 1;
    step(30);
    chk(level, 2'b01, "R10 no vsync yet");
    // clamp over init blanking
    hsync = 1; step(1); hsync = 0;
    chk(level, 2'b10, "R5 clamp over init");
    step(CW + 2);
    // first vblank clears init
    vsync = 1; step(1); vsync = 0;
    step(VS - 1);
    chk(level, 2'b01, "R6 short end-1");
    step(1);
    chk(level, 2'b00, "R10 scan after first vblank");
    // R4 retrigger during clamp
    hsync = 1; step(1); hsync = 0; step(2); hsync = 1; step(1); hsync = 0;
    step(CW - 4);
    chk(level, 2'b10, "R4 clamp last cycle");
    step(1);
    chk(level, 2'b00, "R4 no extension");
    step(5);
    // R3 trailing edge
    lead = 0;
    hsync = 1; step(1);
    chk(level, 2'b00, "R3 rising edge ignored");
    step(3); hsync = 0; step(1);
    chk(level, 2'b10, "R3 clamp on fall");
    step(CW);
    chk(level, 2'b00, "R3 clamp ended");
    lead = 1;
    // R7 retrigger vblank, R6 long with capture
    vlong = 1;
    vsync = 1; step(1); vsync = 0; vlong = 0;
    step(9); vsync = 1; step(1); vsync = 0;
    step(VL - 11);
    chk(level, 2'b01, "R6 long last cycle");
    step(1);
    chk(level, 2'b00, "R7 no extension");
    // R8 each fault
    ss = 1; step(1); chk(level, 2'b01, "R8 softstart"); ss = 0;
    nfb = 1; step(1); chk(level, 2'b01, "R8 no flyback"); nfb = 0;
    xr = 1; step(1); chk(level, 2'b01, "R8 xray"); xr = 0;
    lows = 1; step(1); chk(level, 2'b01, "R8 low supply"); lows = 0;
    step(1); chk(level, 2'b00, "R8 released");
    // R9 unlock blanking
    hu = 1; step(1); chk(level, 2'b00, "R9 unlock without search");
    srch = 1; step(1); chk(level, 2'b01, "R9 unlock in search");
    uoff = 1; step(1); chk(level, 2'b00, "R9 masked");
    vsync = 1; step(1); vsync = 0;
    chk(level, 2'b01, "R9 vblank kept while masked");
    step(VS + 2); hu = 0; srch = 0; uoff = 0;
    // constrained random phase
    begin
      int hc, vc, fc;
      void'($urandom(32'h5CA57));
      hc = 5; vc = 300; fc = 0;
      for (int i = 0; i < 20000; i++) begin
        step(1);
        if (hc == 0) begin
          hsync = ~hsync;
          hc = hsync ? $urandom_range(12, 3) : $urandom_range(40, 2);
        end else hc--;
        vsync = (vc < 3);
        if (vc == 0) vc = $urandom_range(700, 30); else vc--;
        if ($urandom_range(499, 0) == 0) lead = ~lead;
        if ($urandom_range(499, 0) == 0) vlong = ~vlong;
        if ($urandom_range(499, 0) == 0) uoff = ~uoff;
        if (fc == 0) begin
          {ss, nfb, xr, lows, hu, srch} = '0;
          if ($urandom_range(99, 0) == 0) begin
            {ss, nfb, xr, lows, hu, srch} = 6'($urandom_range(63, 1));
            fc = $urandom_range(50, 5);
          end
        end else fc--;
      end
    end
    step(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule